// File: doc/BRIEF.md
# Serial Byte Calculator Sequencer

This block runs a tiny calculator from a stream of received bytes. Each byte arrives with a one-cycle valid strobe. The first byte is taken as operand X and the second as the operator. Only the low three bits of the operator select the operation. The third byte is operand Y. The arithmetic is done by an 8-bit ripple-carry unit inside the block.

After the three bytes are in, results are released in stages, and each stage waits for one more keypress of any value. The first extra byte makes the block send the result byte to a serial transmitter, using a send/ready handshake. The next extra byte puts the result on an 8-bit value meant for a two-digit hex display. The byte after that starts a new calculation.

While operands and the operator are entered, the display value follows each byte. A debug input switches the display to the current state code instead.

Top module: `byte_calc_seq`

## Requirements
- R1: A synchronous reset puts the block in state code 0 (waiting for operand X), clears the display value to 0x00 and deasserts the send strobe.
- R2: In state 0, a received byte is stored as operand X, shown on the display the next cycle, and the state becomes 1.
- R3: In state 1, a received byte is the operator: its bits [2:0] are the operation code. The whole byte is shown on the display and the state becomes 2.
- R4: In state 2, a received byte is stored as operand Y, shown on the display, and the state becomes 3.
- R5: In state 3, a received byte of any value moves the block to state 4. In state 4 the send strobe is high and the transmit byte holds the result. The display keeps operand Y.
- R6: The send strobe stays high, with a stable transmit byte, until the cycle in which transmit-ready is high. It then drops, so there is exactly one handshake per result. Bytes received in state 4 are ignored, even when one arrives in the handshake cycle. After the handshake the state is 5.
- R7: In state 5, a received byte of any value puts the result on the display and returns the block to state 0. The next byte is then a new operand X.
- R8: While the debug input is high, the display output is the 3-bit state code, zero-extended to 8 bits. The state codes are 0 for X, 1 for operator, 2 for Y, 3 for armed, 4 for sending and 5 for result pending.
- R9: The operation codes are as follows. 001 gives X+Y. 010 gives X+Y plus the stored carry. 011 gives X-Y, computed as X+~Y+1. 100 gives X+1. 101 gives ~X. 000, 110 and 111 give X. All results are taken modulo 256.
- R10: The stored carry is the adder's carry-out, captured when the result is latched on entry to state 4. Reset clears it to 0. For subtraction, the carry is 1 when X >= Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking rx_data valid |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| show_state | input | 1 | Debug: display the state code |
| tx_data | output | 8 | Result byte to transmit |
| tx_send | output | 1 | Send request, held until tx_ready |
| hex_value | output | 8 | Value for the two-digit hex display |
| state_code | output | 3 | Current sequencer state |

## Verification
The two functions that can fall in the same cycle are completion of the transmit handshake and arrival of a keypress while the block is sending. The bench provokes this by raising tx_ready and rx_valid together. It then checks that the result is handed over exactly once, that the state moves to 5, and that the stray byte leaves the display on operand Y. It also checks that the stray byte does not advance the sequence to the display stage. A second stray byte, sent while ready is still low, must leave the strobe and the transmit byte unchanged.

// File: rtl/byte_calc_seq.sv
module byte_calc_seq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rx_data,
  input  logic         rx_valid,
  input  logic         tx_ready,
  input  logic         show_state,
  output logic [W-1:0] tx_data,
  output logic         tx_send,
  output logic [W-1:0] hex_value,
  output logic [2:0]   state_code
);

  localparam logic [2:0] S_X    = 3'd0;
  localparam logic [2:0] S_OP   = 3'd1;
  localparam logic [2:0] S_Y    = 3'd2;
  localparam logic [2:0] S_ARM  = 3'd3;
  localparam logic [2:0] S_SEND = 3'd4;
  localparam logic [2:0] S_SHOW = 3'd5;

  localparam logic [2:0] OP_ADD = 3'b001;
  localparam logic [2:0] OP_ADC = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b011;
  localparam logic [2:0] OP_INC = 3'b100;
  localparam logic [2:0] OP_NOT = 3'b101;

  logic [2:0]   st;
  logic [W-1:0] x_q, y_q, disp_q, res_q;
  logic [2:0]   op_q;
  logic         carry_q;

  logic [W-1:0] a_in, b_in, sum;
  logic         c_in;
  logic [W:0]   cy;

  always_comb begin
    a_in = x_q;
    b_in = '0;
    c_in = 1'b0;
    case (op_q)
      OP_ADD: b_in = y_q;
      OP_ADC: begin b_in = y_q; c_in = carry_q; end
      OP_SUB: begin b_in = ~y_q; c_in = 1'b1; end
      OP_INC: c_in = 1'b1;
      OP_NOT: a_in = ~x_q;
      default: ;
    endcase
  end

  assign cy[0] = c_in;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_rip
      assign sum[i]  = a_in[i] ^ b_in[i] ^ cy[i];
      assign cy[i+1] = (a_in[i] & b_in[i]) | (cy[i] & (a_in[i] ^ b_in[i]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_X;
      x_q     <= '0;
      y_q     <= '0;
      op_q    <= '0;
      disp_q  <= '0;
      res_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      case (st)
        S_X: if (rx_valid) begin
          x_q    <= rx_data;
          disp_q <= rx_data;
          st     <= S_OP;
        end
        S_OP: if (rx_valid) begin
          op_q   <= rx_data[2:0];
          disp_q <= rx_data;
          st     <= S_Y;
        end
        S_Y: if (rx_valid) begin
          y_q    <= rx_data;
          disp_q <= rx_data;
          st     <= S_ARM;
        end
        S_ARM: if (rx_valid) begin
          res_q   <= sum;
          carry_q <= cy[W];
          st      <= S_SEND;
        end
        S_SEND: if (tx_ready) st <= S_SHOW;
        S_SHOW: if (rx_valid) begin
          disp_q <= res_q;
          st     <= S_X;
        end
        default: st <= S_X;
      endcase
    end
  end

  assign tx_send    = (st == S_SEND);
  assign tx_data    = res_q;
  assign state_code = st;
  assign hex_value  = show_state ? W'(st) : disp_q;

endmodule

// File: rtl/byte_calc_seq_chk.sv
module byte_calc_seq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         rx_valid,
  input logic         tx_ready,
  input logic         show_state,
  input logic         tx_send,
  input logic [W-1:0] tx_data,
  input logic [W-1:0] hex_value,
  input logic [2:0]   state_code,
  input logic [W-1:0] disp_q
);

  // R6
  send_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_send && !tx_ready |=> tx_send && $stable(tx_data));

  // R6
  single_send_chk: assert property (@(posedge clk) disable iff (rst)
    tx_send && tx_ready |=> !tx_send && state_code == 3'd5);

  // R8
  state_range_chk: assert property (@(posedge clk) disable iff (rst)
    state_code <= 3'd5);

  // R2
  take_x_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd0 && rx_valid |=> state_code == 3'd1);

  // R8
  debug_view_chk: assert property (@(posedge clk) disable iff (rst)
    show_state |-> hex_value == W'(state_code));

  // R6
  disp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(disp_q));

  // R5
  arm_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd3 && rx_valid |=> tx_send);

endmodule

bind byte_calc_seq byte_calc_seq_chk #(.W(W)) chk (.*);

// File: tb/byte_calc_seq_test.sv
`timescale 1ns/1ps
module byte_calc_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0;
  logic       tx_ready = 1'b0;
  logic       show_state = 1'b0;
  logic [7:0] tx_data, hex_value;
  logic       tx_send;
  logic [2:0] state_code;

  int errors = 0, checks = 0, handshakes = 0;
  logic [7:0] exp_q[$];
  logic       carry_m = 1'b0;

  always #2 clk = ~clk;

  byte_calc_seq uut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_ready(tx_ready), .show_state(show_state), .tx_data(tx_data),
    .tx_send(tx_send), .hex_value(hex_value), .state_code(state_code)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic send(logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    tick();
    rx_valid = 1'b0;
  endtask

  function automatic logic [8:0] model(logic [7:0] x, logic [2:0] op, logic [7:0] y, logic c);
    int unsigned r;
    case (op)
      3'b001: r = x + y;
      3'b010: r = x + y + c;
      3'b011: r = x + ((~y) & 8'hFF) + 1;
      3'b100: r = x + 1;
      3'b101: r = (~x) & 8'hFF;
      default: r = x;
    endcase
    return r[8:0];
  endfunction

  always @(negedge clk) begin
    if (!rst && tx_send && tx_ready) begin
      handshakes++;
      if (exp_q.size() == 0) check("R6 unexpected send", tx_data, 8'h00);
      else check("R5 R9 result byte", tx_data, exp_q.pop_front());
    end
  end

  task automatic calc(logic [7:0] x, logic [7:0] opch, logic [7:0] y, int hold);
    logic [8:0] m;
    m = model(x, opch[2:0], y, carry_m);
    send(x);
    check("R2 operand X shown", hex_value, x);
    send(opch);
    check("R3 operator shown", hex_value, opch);
    send(y);
    check("R4 operand Y shown", hex_value, y);
    exp_q.push_back(m[7:0]);
    send(8'h20);
    check("R5 send raised", {7'd0, tx_send}, 8'd1);
    check("R5 display keeps Y", hex_value, y);
    check("R10 R9 tx byte", tx_data, m[7:0]);
    carry_m = m[8];
    for (int k = 0; k < hold; k++) begin
      tick();
      check("R6 send held", {7'd0, tx_send}, 8'd1);
    end
    send(8'hEE);
    check("R6 stray byte ignored, still sending", {7'd0, tx_send}, 8'd1);
    check("R6 stray byte not displayed", hex_value, y);
    rx_data = 8'h77; rx_valid = 1'b1; tx_ready = 1'b1;
    tick();
    rx_valid = 1'b0; tx_ready = 1'b0;
    check("R6 send dropped after handshake", {7'd0, tx_send}, 8'd0);
    check("R6 coincident byte not displayed", hex_value, y);
    show_state = 1'b1; #0.5;
    check("R8 state 5 shown", hex_value, 8'd5);
    show_state = 1'b0; #0.5;
    send(8'h31);
    check("R7 result displayed", hex_value, m[7:0]);
    check("R7 back to state 0", {5'd0, state_code}, 8'd0);
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    check("R1 display cleared", hex_value, 8'h00);
    check("R1 state 0", {5'd0, state_code}, 8'd0);
    check("R1 no send", {7'd0, tx_send}, 8'd0);
    show_state = 1'b1; #0.5;
    check("R8 state 0 shown", hex_value, 8'd0);
    show_state = 1'b0; #0.5;

    calc(8'h41, 8'h21, 8'h04, 3);
    calc(8'h01, 8'h23, 8'h02, 0);
    check("R10 borrow clears carry", {7'd0, carry_m}, 8'd0);
    calc(8'hFF, 8'h22, 8'h02, 1);
    calc(8'h10, 8'h22, 8'h20, 2);
    calc(8'h7F, 8'h24, 8'h00, 0);
    calc(8'h0F, 8'h25, 8'h99, 1);
    calc(8'h5A, 8'h28, 8'h11, 0);
    calc(8'h80, 8'h23, 8'h01, 0);

    send(8'h12);
    show_state = 1'b1; #0.5;
    check("R8 state 1 shown", hex_value, 8'd1);
    show_state = 1'b0; #0.5;
    check("R7 new X after result", hex_value, 8'h12);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 reset mid-entry clears display", hex_value, 8'h00);
    check("R1 reset mid-entry state", {5'd0, state_code}, 8'd0);

    tick(); tick();
    check("R6 one handshake per result", 8'(handshakes), 8'd8);
    check("R6 scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule